// File: doc/BRIEF.md
# Cross-Lane Operand Sharing Unit

This block prepares the source operand of a vector instruction when lanes exchange data. It takes a full wavefront of source data (64 lanes by default), the previous contents of the destination and an execute mask. It returns, one clock later, a new per-lane operand vector. Every destination lane either takes a value from another lane, keeps its previous value or receives zero. The choice depends on a pattern opcode, row and bank enable masks, and two policy bits. One policy bit covers sources that fall outside their row or wavefront. The other covers sources whose execute bit is clear.

Lanes are grouped into rows of sixteen. Each row holds four banks of four lanes. In half-wave mode only the lower two rows take part. Lanes 32 and above keep their previous values and cannot act as sources. A separate eight-lane mode replaces the opcode with eight 3-bit selectors. The same selectors apply to every group of eight lanes.

Top module: `xls_share`

## Requirements
- R1: The result register and `out_valid` load on every cycle with `in_valid` high, so the result appears one clock after the inputs. With `in_valid` low, `out_valid` falls and `result` holds its value. Reset clears both.
- R2: An opcode with bit 8 at zero is a quad permute. Lane q of each group of four reads group lane `op[2q+1:2q]`.
- R3: Row shifts and rotates use opcode `0x100|n` for shift left (source lane i+n), `0x110|n` for shift right (source lane i-n) and `0x120|n` for rotate right (source lane (i-n) mod 16 within the row), with n from 1 to 15. A shift source that leaves its row is invalid.
- R4: Opcode `0x140` mirrors lanes within each row of 16. Opcode `0x141` mirrors lanes within each group of 8.
- R5: Opcode `0x150|n` makes every lane read lane n of its own row. Opcode `0x160|n` makes a lane read the in-row index equal to its own in-row index XOR n.
- R6: The wave-wide patterns act over 32 or 64 lanes, following `wave32`. They are `0x130` shift left (source i+1), `0x131` rotate left, `0x132` shift right (source i-1) and `0x133` rotate right. A shift source past either end of the wave is invalid.
- R7: Opcode `0x142` makes each row from row 1 upward read the last lane of the row below it. Opcode `0x143` makes rows 2 and 3 read lane 31. For lanes in rows that a broadcast does not target, the source is invalid.
- R8: A destination lane keeps its previous value in four cases: its execute bit is clear, its row-enable bit is clear, its bank-enable bit is clear (bank = in-row index / 4), or `wave32` is set and the lane is 32 or above.
- R9: For an enabled lane with an invalid source, the result is zero when `bound_zero` is 1 and the previous value when it is 0. Any opcode not listed in R2 to R7 makes every source invalid.
- R10: Outside eight-lane mode, a valid source whose execute bit is clear supplies its data when `fetch_inact` is 1. When `fetch_inact` is 0, the lane is treated as having an invalid source (R9).
- R11: With `mode8` set, lane k of each group of eight reads group lane `sel8[3k+2:3k]`, and the row and bank masks have no effect. An inactive source gives zero when `fetch_inact` is 0 and its data when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls present this cycle |
| wave32 | input | 1 | Half-wave mode (lower 32 lanes only) |
| mode8 | input | 1 | Use the eight-lane selectors instead of the opcode |
| op | input | 9 | Sharing pattern opcode |
| sel8 | input | 24 | Eight 3-bit lane selectors |
| row_en | input | ROWS | Destination row enables |
| bank_en | input | 4 | Destination bank enables |
| bound_zero | input | 1 | Invalid source yields zero instead of the previous value |
| fetch_inact | input | 1 | Inactive source still supplies its data |
| exec | input | LANES | Execute mask |
| src | input | LANES*DW | Source data, lane i at bits [i*DW +: DW] |
| prev | input | LANES*DW | Previous destination data |
| out_valid | output | 1 | Result loaded on the previous clock |
| result | output | LANES*DW | New operand vector |

## Verification
The hardest case to reach is a lane whose source is valid in position but inactive. The `fetch_inact` and `bound_zero` policies decide the outcome only there, and in eight-lane mode the zero rule differs from the row patterns. The stimulus pairs sparse and striped execute masks with row share, XOR-mask and eight-lane selectors, so that many enabled lanes point at lanes with a clear execute bit. Each such vector then runs under both policy settings. Row-end and wave-end shifts, along with broadcasts into untargeted rows, are driven with `bound_zero` both set and clear to separate the zero outcome from the keep outcome.

// File: rtl/xls_pkg.sv
package xls_pkg;
   // pattern groups, selected by op[7:4] when op[8] is set
   localparam logic [3:0] GRP_ROW_SHL  = 4'h0;
   localparam logic [3:0] GRP_ROW_SHR  = 4'h1;
   localparam logic [3:0] GRP_ROW_ROR  = 4'h2;
   localparam logic [3:0] GRP_WAVE     = 4'h3;
   localparam logic [3:0] GRP_MIRROR   = 4'h4;
   localparam logic [3:0] GRP_SHARE    = 4'h5;
   localparam logic [3:0] GRP_XMASK    = 4'h6;
   // sub-codes inside the wave and mirror groups
   localparam int SUB_WAVE_SHL = 0;
   localparam int SUB_WAVE_ROL = 1;
   localparam int SUB_WAVE_SHR = 2;
   localparam int SUB_WAVE_ROR = 3;
   localparam int SUB_MIR_ROW  = 0;
   localparam int SUB_MIR_HALF = 1;
   localparam int SUB_BCAST_LO = 2;
   localparam int SUB_BCAST_HI = 3;
   localparam int ROW_LANES  = 16;
   localparam int BANK_LANES = 4;
   localparam int GRP8_LANES = 8;
endpackage

// File: rtl/xls_src_route.sv
module xls_src_route
   import xls_pkg::*;
#(
   parameter int ROWS = 4,
   parameter int LANE = 0,
   localparam int LANES = ROWS * ROW_LANES,
   localparam int IDXW  = $clog2(LANES)
) (
   input  logic [8:0]      op,
   input  logic [23:0]     sel8,
   input  logic            mode8,
   input  logic            wave32,
   output logic [IDXW-1:0] src_idx,
   output logic            src_ok
);
   localparam int ROW  = LANE / ROW_LANES;
   localparam int COL  = LANE % ROW_LANES;
   localparam int RBAS = LANE - COL;
   localparam int HALF = ROW_LANES / 2;
   localparam int HBAS = LANE - (LANE % HALF);
   localparam int QPOS = LANE % 4;
   localparam int QBAS = LANE - QPOS;
   localparam int OPOS = LANE % GRP8_LANES;
   localparam int OBAS = LANE - OPOS;

   always_comb begin
      int t;
      int wl;
      int n;
      logic ok;
      wl = wave32 ? LANES / 2 : LANES;
      n  = int'(op[3:0]);
      t  = 0;
      ok = 1'b1;
      if (mode8) begin
         t = OBAS + int'(sel8[3*OPOS +: 3]);
      end else if (!op[8]) begin
         t = QBAS + int'(op[2*QPOS +: 2]);
      end else begin
         case (op[7:4])
            GRP_ROW_SHL: begin ok = (n != 0) && (COL + n < ROW_LANES); t = LANE + n; end
            GRP_ROW_SHR: begin ok = (n != 0) && (COL >= n); t = LANE - n; end
            GRP_ROW_ROR: begin ok = (n != 0); t = RBAS + ((COL + ROW_LANES - n) % ROW_LANES); end
            GRP_WAVE: begin
               case (n)
                  SUB_WAVE_SHL: t = LANE + 1;
                  SUB_WAVE_ROL: t = (LANE + 1) % wl;
                  SUB_WAVE_SHR: t = LANE - 1;
                  SUB_WAVE_ROR: t = (LANE + wl - 1) % wl;
                  default:      ok = 1'b0;
               endcase
            end
            GRP_MIRROR: begin
               case (n)
                  SUB_MIR_ROW:  t = RBAS + ROW_LANES - 1 - COL;
                  SUB_MIR_HALF: t = HBAS + HALF - 1 - (LANE % HALF);
                  SUB_BCAST_LO: begin ok = (ROW >= 1); t = RBAS - 1; end
                  SUB_BCAST_HI: begin ok = (ROW >= 2); t = 2 * ROW_LANES - 1; end
                  default:      ok = 1'b0;
               endcase
            end
            GRP_SHARE: t = RBAS + n;
            GRP_XMASK: t = RBAS + (COL ^ n);
            default:   ok = 1'b0;
         endcase
      end
      if (t < 0 || t >= wl) ok = 1'b0;
      src_ok  = ok;
      src_idx = ok ? IDXW'(t) : '0;
   end
endmodule

// File: rtl/xls_lane_pick.sv
module xls_lane_pick #(
   parameter int DW = 32
) (
   input  logic          lane_en,
   input  logic          src_ok,
   input  logic          src_act,
   input  logic          mode8,
   input  logic          bound_zero,
   input  logic          fetch_inact,
   input  logic [DW-1:0] src_val,
   input  logic [DW-1:0] prev_val,
   output logic [DW-1:0] nxt_val
);
   always_comb begin
      if (!lane_en)
         nxt_val = prev_val;
      else if (!src_ok)
         nxt_val = bound_zero ? '0 : prev_val;
      else if (!src_act && !fetch_inact)
         nxt_val = (mode8 || bound_zero) ? '0 : prev_val;
      else
         nxt_val = src_val;
   end
endmodule

// File: rtl/xls_share.sv
module xls_share
   import xls_pkg::*;
#(
   parameter int DW   = 32,
   parameter int ROWS = 4,
   localparam int LANES = ROWS * ROW_LANES,
   localparam int BANKS = ROW_LANES / BANK_LANES,
   localparam int VW    = LANES * DW,
   localparam int IDXW  = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             wave32,
   input  logic             mode8,
   input  logic [8:0]       op,
   input  logic [23:0]      sel8,
   input  logic [ROWS-1:0]  row_en,
   input  logic [BANKS-1:0] bank_en,
   input  logic             bound_zero,
   input  logic             fetch_inact,
   input  logic [LANES-1:0] exec,
   input  logic [VW-1:0]    src,
   input  logic [VW-1:0]    prev,
   output logic             out_valid,
   output logic [VW-1:0]    result
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("xls_share: DW must be at least 1");
      end
      if (ROWS != 2 && ROWS != 4) begin : g_bad_rows
         $error("xls_share: ROWS must be 2 or 4");
      end
   endgenerate

   logic [DW-1:0] src_lane [LANES];
   logic [VW-1:0] nxt;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int ROW = i / ROW_LANES;
      localparam int BNK = (i % ROW_LANES) / BANK_LANES;
      logic [IDXW-1:0] sidx;
      logic            sok;
      logic            en;

      assign src_lane[i] = src[i*DW +: DW];

      xls_src_route #(.ROWS(ROWS), .LANE(i)) u_route (
         .op      (op),
         .sel8    (sel8),
         .mode8   (mode8),
         .wave32  (wave32),
         .src_idx (sidx),
         .src_ok  (sok)
      );

      if (i < LANES / 2) begin : g_low
         assign en = exec[i] && (mode8 || (row_en[ROW] && bank_en[BNK]));
      end else begin : g_high
         assign en = !wave32 && exec[i] && (mode8 || (row_en[ROW] && bank_en[BNK]));
      end

      xls_lane_pick #(.DW(DW)) u_pick (
         .lane_en     (en),
         .src_ok      (sok),
         .src_act     (exec[sidx]),
         .mode8       (mode8),
         .bound_zero  (bound_zero),
         .fetch_inact (fetch_inact),
         .src_val     (src_lane[sidx]),
         .prev_val    (prev[i*DW +: DW]),
         .nxt_val     (nxt[i*DW +: DW])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= nxt;
      end
   end
endmodule

// File: rtl/xls_share_chk.sv
module xls_share_chk #(
   parameter int DW   = 32,
   parameter int ROWS = 4,
   localparam int LANES = ROWS * 16,
   localparam int VW    = LANES * DW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             wave32,
   input logic             mode8,
   input logic [23:0]      sel8,
   input logic [3:0]       bank_en,
   input logic             fetch_inact,
   input logic [LANES-1:0] exec,
   input logic [VW-1:0]    src,
   input logic [VW-1:0]    prev,
   input logic             out_valid,
   input logic [VW-1:0]    result
);
   p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));

   p_exec_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !exec[0]) |=> result[DW-1:0] == $past(prev[DW-1:0]));

   p_bank_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode8 && !bank_en[0]) |=> result[DW-1:0] == $past(prev[DW-1:0]));

   p_half_wave_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wave32) |=> result[VW-1 -: DW] == $past(prev[VW-1 -: DW]));

   p_sel8_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode8 && fetch_inact && exec[0])
         |=> result[DW-1:0] == $past(src[DW*int'(sel8[2:0]) +: DW]));
endmodule

bind xls_share xls_share_chk #(.DW(DW), .ROWS(ROWS)) u_chk (.*);

// File: tb/xls_share_tb.sv
module xls_share_tb;
   localparam int DW = 32;
   localparam int LANES = 64;
   localparam int VW = LANES * DW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             wave32 = 1'b0;
   logic             mode8 = 1'b0;
   logic [8:0]       op = '0;
   logic [23:0]      sel8 = '0;
   logic [3:0]       row_en = 4'hF;
   logic [3:0]       bank_en = 4'hF;
   logic             bound_zero = 1'b0;
   logic             fetch_inact = 1'b0;
   logic [LANES-1:0] exec = '1;
   logic [VW-1:0]    src = '0;
   logic [VW-1:0]    prev = '0;
   logic             out_valid;
   logic [VW-1:0]    result;

   int n_cmp = 0;
   int n_bad = 0;
   logic [VW-1:0] exp_q [$];
   string         tag_q [$];
   logic [VW-1:0] last_exp = '0;

   always #2ns clk = ~clk;

   xls_share #(.DW(DW), .ROWS(4)) u_dut (.*);

   function automatic logic [VW-1:0] model(
      input logic w32, input logic m8, input logic [8:0] opc, input logic [23:0] s8,
      input logic [3:0] rm, input logic [3:0] bm, input logic bz, input logic fi,
      input logic [63:0] ex, input logic [VW-1:0] sv, input logic [VW-1:0] pv);
      logic [VW-1:0] o;
      o = '0;
      for (int d = 0; d < LANES; d++) begin
         int wl, r, c, s, n;
         logic ok, en;
         wl = w32 ? 32 : 64;
         r = d / 16; c = d % 16; n = int'(opc[3:0]);
         en = (d < wl) && ex[d] && (m8 || (rm[r] && bm[c/4]));
         s = 0; ok = 1'b1;
         if (m8) s = (d / 8) * 8 + int'(s8[3*(d%8) +: 3]);
         else if (!opc[8]) s = (d / 4) * 4 + int'(opc[2*(d%4) +: 2]);
         else begin
            case (opc[7:4])
               4'h0: begin ok = (n != 0) && (c + n < 16); s = d + n; end
               4'h1: begin ok = (n != 0) && (c >= n); s = d - n; end
               4'h2: begin ok = (n != 0); s = r * 16 + (c + 16 - n) % 16; end
               4'h3: case (n)
                        0: s = d + 1;
                        1: s = (d + 1) % wl;
                        2: s = d - 1;
                        3: s = (d + wl - 1) % wl;
                        default: ok = 1'b0;
                     endcase
               4'h4: case (n)
                        0: s = r * 16 + 15 - c;
                        1: s = (d / 8) * 8 + 7 - d % 8;
                        2: begin ok = (r >= 1); s = r * 16 - 1; end
                        3: begin ok = (r >= 2); s = 31; end
                        default: ok = 1'b0;
                     endcase
               4'h5: s = r * 16 + n;
               4'h6: s = r * 16 + (c ^ n);
               default: ok = 1'b0;
            endcase
         end
         if (s < 0 || s >= wl) ok = 1'b0;
         if (!en) o[d*DW +: DW] = pv[d*DW +: DW];
         else if (!ok) o[d*DW +: DW] = bz ? '0 : pv[d*DW +: DW];
         else if (!ex[s] && !fi) o[d*DW +: DW] = (m8 || bz) ? '0 : pv[d*DW +: DW];
         else o[d*DW +: DW] = sv[s*DW +: DW];
      end
      return o;
   endfunction

   task automatic send(input string tag, input logic w32, input logic m8, input logic [8:0] opc,
                       input logic [23:0] s8, input logic [3:0] rm, input logic [3:0] bm,
                       input logic bz, input logic fi, input logic [63:0] ex, input int seed);
      logic [VW-1:0] sv, pv;
      for (int i = 0; i < LANES; i++) begin
         sv[i*DW +: DW] = {8'(seed), 8'h5A, 8'(i), 8'(i * 3 + 1)};
         pv[i*DW +: DW] = {8'hEE, 8'(seed), 8'(i), 8'h11};
      end
      @(negedge clk);
      in_valid = 1'b1; wave32 = w32; mode8 = m8; op = opc; sel8 = s8;
      row_en = rm; bank_en = bm; bound_zero = bz; fetch_inact = fi;
      exec = ex; src = sv; prev = pv;
      exp_q.push_back(model(w32, m8, opc, s8, rm, bm, bz, fi, ex, sv, pv));
      tag_q.push_back(tag);
   endtask

   // monitor: pops one expected vector for each produced result
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
               n_bad++;
               $display("FAIL unexpected result: out_valid actual 1 expected 0");
            end else begin
               logic [VW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               last_exp = e;
               if (result !== e) begin
                  n_bad++;
                  for (int i = 0; i < LANES; i++) begin
                     if (result[i*DW +: DW] !== e[i*DW +: DW]) begin
                        $display("FAIL %s lane %0d: actual %h expected %h", t, i,
                                 result[i*DW +: DW], e[i*DW +: DW]);
                        break;
                     end
                  end
               end
            end
         end
      end
   end

   initial begin
      #(800_000ns);
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      n_cmp++;
      if (out_valid !== 1'b0 || result !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: actual valid %b result nonzero %b expected 0 0", out_valid, |result);
      end
      @(negedge clk);
      rst_n = 1'b1;

      send("R2 quad reverse",      0, 0, 9'h01B, '0, 4'hF, 4'hF, 0, 0, '1, 1);
      send("R2 quad mixed exec",   0, 0, 9'h072, '0, 4'hF, 4'hF, 1, 0, 64'hF0F0_3C3C_A5A5_0FF0, 2);
      send("R3 row shl 3 zero",    0, 0, 9'h103, '0, 4'hF, 4'hF, 1, 0, '1, 3);
      send("R3 row shr 5 keep",    0, 0, 9'h115, '0, 4'hF, 4'hF, 0, 0, '1, 4);
      send("R3 row ror 7",         0, 0, 9'h127, '0, 4'hF, 4'hF, 0, 0, '1, 5);
      send("R3 row shl 0 invalid", 0, 0, 9'h100, '0, 4'hF, 4'hF, 1, 0, '1, 6);
      send("R4 row mirror",        0, 0, 9'h140, '0, 4'hF, 4'hF, 0, 0, '1, 7);
      send("R4 half mirror",       0, 0, 9'h141, '0, 4'hF, 4'hF, 0, 0, '1, 8);
      send("R5 row share 9",       0, 0, 9'h159, '0, 4'hF, 4'hF, 0, 0, '1, 9);
      send("R5 row xmask 5",       0, 0, 9'h165, '0, 4'hF, 4'hF, 0, 0, '1, 10);
      send("R6 wave shl 64 zero",  0, 0, 9'h130, '0, 4'hF, 4'hF, 1, 0, '1, 11);
      send("R6 wave ror wave32",   1, 0, 9'h133, '0, 4'hF, 4'hF, 0, 0, '1, 12);
      send("R6 wave rol 64",       0, 0, 9'h131, '0, 4'hF, 4'hF, 0, 0, '1, 13);
      send("R6 wave shr wave32",   1, 0, 9'h132, '0, 4'hF, 4'hF, 1, 0, '1, 14);
      send("R7 bcast row end",     0, 0, 9'h142, '0, 4'hF, 4'hF, 1, 0, '1, 15);
      send("R7 bcast lane 31",     0, 0, 9'h143, '0, 4'hF, 4'hF, 0, 0, '1, 16);
      send("R8 row and bank mask", 0, 0, 9'h127, '0, 4'h5, 4'hA, 0, 1, '1, 17);
      send("R8 exec hole fi1",     1, 0, 9'h01B, '0, 4'h3, 4'h7, 0, 1, 64'h1234_5678_9ABC_DEF0, 18);
      send("R9 unknown op zero",   0, 0, 9'h1F0, '0, 4'hF, 4'hF, 1, 0, '1, 19);
      send("R9 unknown op keep",   0, 0, 9'h14C, '0, 4'hF, 4'hF, 0, 0, '1, 20);
      send("R10 inactive bz1",     0, 0, 9'h153, '0, 4'hF, 4'hF, 1, 0, 64'hFFF7_FFF7_FFF7_FFF7, 21);
      send("R10 inactive bz0",     0, 0, 9'h165, '0, 4'hF, 4'hF, 0, 0, 64'h5555_AAAA_5555_AAAA, 22);
      send("R10 inactive fetch",   0, 0, 9'h165, '0, 4'hF, 4'hF, 0, 1, 64'h5555_AAAA_5555_AAAA, 23);
      send("R11 sel8 reverse fi0", 0, 1, 9'h000, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7},
           4'h0, 4'h0, 0, 0, 64'h0F0F_3333_5555_F00F, 24);
      send("R11 sel8 wave32 fi1",  1, 1, 9'h000, {3'd1,3'd0,3'd1,3'd0,3'd1,3'd0,3'd1,3'd0},
           4'h0, 4'h3, 1, 1, 64'hFFFF_FFFF_0F0F_0F0F, 25);
      send("R11 sel8 bz ignored",  0, 1, 9'h000, {3'd7,3'd7,3'd2,3'd2,3'd5,3'd5,3'd0,3'd0},
           4'hF, 4'hF, 0, 0, 64'hFEFE_FEFE_FEFE_FEFE, 26);

      @(negedge clk);
      in_valid = 1'b0;
      src = '1; prev = '0;
      repeat (4) @(negedge clk);
      // R1: idle cycles hold the last result
      n_cmp++;
      if (out_valid !== 1'b0 || result !== last_exp || exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R1 idle hold: actual valid %b pending %0d expected valid 0 pending 0 held",
                  out_valid, exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule